// File: doc/BRIEF.md
# Register-Window AXI4-Lite Transfer Bridge

This block lets a host that only sees a narrow window of 16-bit registers run single 32-bit transactions on an AXI4-Lite master port. The host first loads the target address as two 16-bit halves. For a write it also loads the 32-bit payload as two halves. It then writes an encoded command into the control register. The bridge latches the transfer and drives one AXI4-Lite beat. It reports the outcome through sticky event flags in the status register, which the host polls. The result of a read is held in two 16-bit read-back registers.

Each event flag has its own enable bit in the control register, at the same bit position as the flag. A flag only rises when its enable is set. The host clears a flag by writing 1 to it. Commands that post-increment advance the stored address by one word after a successful transfer, so a host can walk a block of consecutive words without reloading the address. A cycle counter bounds the wait for a response. When the wait runs out, the bridge abandons the transfer and reports a timeout.

Top module: `axbr_bridge`

## Requirements
- R1: After reset, every register reads zero except status bit 5 (initialization done). From the first clock edge after reset is released, status reads 0x0020.
- R2: The window has eight registers, selected by the 3-bit index: 0 status, 1 control, 2 address[15:0], 3 address[31:16], 4 write data[15:0], 5 write data[31:16], 6 read data[15:0], 7 read data[31:16]. The issued AXI address and write data are the concatenation {high, low}, and the write strobe is always 4'hF.
- R3: Command 0x8 (write) or 0x9 (write with post-increment) in control bits 3:0 raises AWVALID and WVALID in the same cycle. Each is held with a stable payload until its own ready. Status bit 6 (busy) reads 1 from acceptance until the transfer ends.
- R4: Command 0xA (read) or 0xB (read with post-increment) raises ARVALID, held until ARREADY. After an OKAY response, the returned word is readable as {index 7, index 6} and status bit 7 (read data available) is set. Acceptance of any command clears bit 7.
- R5: Status bits 15 (read done), 14 (write done), 13 (timeout), 12 (error) and 11 (external interrupt) can only rise while the control bit at the same position is 1.
- R6: Event bits stay set until the host writes status with a 1 in that bit position. Writing 0 leaves them unchanged.
- R7: After an OKAY response, commands 0x9 and 0xB add 4 to the stored 32-bit address, visible at indices 2 and 3. Commands 0x8 and 0xA leave the address unchanged.
- R8: A non-OKAY response (SLVERR or DECERR) raises bit 12 in place of the completion bit. It leaves the address and the read data unchanged.
- R9: If no response arrives within TIMEOUT_LIMIT cycles of acceptance, the bridge raises bit 13, clears busy and drops every valid. Busy lasts exactly TIMEOUT_LIMIT cycles.
- R10: A command written while busy is ignored, and so is a code other than 0x8 to 0xB (0x0 is the no-operation code). Neither starts nor alters a transfer.
- R11: A high level on ext_irq in a cycle sets status bit 11 when control bit 11 is set.
- R12: At most one transaction is outstanding: read and write channel valids are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_idx | input | 3 | Register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read-back for host_idx (combinational) |
| ext_irq | input | 1 | External interrupt level |
| m_awaddr | output | 32 | AXI write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | Write strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | AXI read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Several properties are checked on every cycle: the single-outstanding rule, AWVALID and WVALID rising together, valid and address holding until their ready, event flags rising only under their enable, flags staying set unless cleared, the transfer staying locked while busy, and the return to idle after a timeout. Other behaviours need the bench's scenarios to show up: the split address and data reaching the bus, the read word coming back in two halves, post-increment against error responses, the exact length of the timeout, and commands being ignored while busy. The bench drives randomised transactions with random slave latency and response codes and compares the results with its own model.

// File: rtl/axbr_pkg.sv
package axbr_pkg;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 2 * HALF_W;
  localparam int IDX_W    = 3;
  localparam int CMD_W    = 4;
  localparam int NUM_EV   = 5;
  localparam int EV_LSB   = 11;
  localparam int AVAIL_B  = 7;
  localparam int BUSY_B   = 6;
  localparam int INIT_B   = 5;
  localparam int STEP     = WORD_W / 8;

  localparam logic [IDX_W-1:0] IDX_STAT = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd1;
  localparam logic [IDX_W-1:0] IDX_ALO  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_AHI  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_WLO  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_WHI  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_RLO  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_RHI  = 3'd7;

  // event vector positions, offset by EV_LSB in the status word
  localparam int EV_IRQ = 0;
  localparam int EV_ERR = 1;
  localparam int EV_TO  = 2;
  localparam int EV_WR  = 3;
  localparam int EV_RD  = 4;

  // start codes occupy 4'b10xx: bit1 selects read, bit0 post-increment
  function automatic logic cmd_starts(input logic [CMD_W-1:0] c);
    return c[3:2] == 2'b10;
  endfunction

  function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                    input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] advance_addr(input logic [WORD_W-1:0] a);
    return a + WORD_W'(STEP);
  endfunction

  function automatic logic resp_bad(input logic [1:0] r);
    return r != 2'b00;
  endfunction
endpackage

// File: rtl/axbr_regfile.sv
module axbr_regfile
  import axbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [HALF_W-1:0] host_wdata,
  output logic [HALF_W-1:0] host_rdata,
  input  logic              ext_irq,
  input  logic              eng_busy,
  input  logic              eng_resp_fire,
  input  logic              eng_resp_err,
  input  logic              eng_to_fire,
  input  logic [WORD_W-1:0] eng_rdata,
  output logic              cmd_accept,
  output logic              cmd_is_wr,
  output logic [WORD_W-1:0] txn_addr,
  output logic [WORD_W-1:0] txn_wdata,
  output logic [NUM_EV-1:0] evt_q,
  output logic [NUM_EV-1:0] en_q
);
  logic [WORD_W-1:0] addr_q, wdata_q, rdata_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              init_q, avail_q, inc_q, rd_q;
  logic              wr_stat, wr_ctrl, ok_done;
  logic [NUM_EV-1:0] ev_raw, ev_w1c;

  always_comb begin
    wr_stat    = host_wr_en && (host_idx == IDX_STAT);
    wr_ctrl    = host_wr_en && (host_idx == IDX_CTRL);
    cmd_accept = wr_ctrl && cmd_starts(host_wdata[CMD_W-1:0]) && !eng_busy;
    cmd_is_wr  = !host_wdata[1];
    ok_done    = eng_resp_fire && !eng_resp_err;
    ev_raw         = '0;
    ev_raw[EV_RD]  = ok_done && rd_q;
    ev_raw[EV_WR]  = ok_done && !rd_q;
    ev_raw[EV_TO]  = eng_to_fire;
    ev_raw[EV_ERR] = eng_resp_fire && eng_resp_err;
    ev_raw[EV_IRQ] = ext_irq;
    ev_w1c = wr_stat ? host_wdata[EV_LSB +: NUM_EV] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      en_q    <= '0;
      cmd_q   <= '0;
      evt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      avail_q <= 1'b0;
      inc_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      init_q <= 1'b1;
      evt_q  <= (evt_q & ~ev_w1c) | (ev_raw & en_q);
      if (wr_ctrl) begin
        en_q  <= host_wdata[EV_LSB +: NUM_EV];
        cmd_q <= host_wdata[CMD_W-1:0];
      end
      if (cmd_accept) begin
        inc_q   <= host_wdata[0];
        rd_q    <= host_wdata[1];
        avail_q <= 1'b0;
      end
      if (ok_done && inc_q) addr_q <= advance_addr(addr_q);
      if (ok_done && rd_q) begin
        rdata_q <= eng_rdata;
        avail_q <= 1'b1;
      end
      if (host_wr_en && host_idx == IDX_ALO) addr_q[HALF_W-1:0]       <= host_wdata;
      if (host_wr_en && host_idx == IDX_AHI) addr_q[WORD_W-1:HALF_W]  <= host_wdata;
      if (host_wr_en && host_idx == IDX_WLO) wdata_q[HALF_W-1:0]      <= host_wdata;
      if (host_wr_en && host_idx == IDX_WHI) wdata_q[WORD_W-1:HALF_W] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_idx)
      IDX_STAT: begin
        host_rdata[EV_LSB +: NUM_EV] = evt_q;
        host_rdata[AVAIL_B]          = avail_q;
        host_rdata[BUSY_B]           = eng_busy;
        host_rdata[INIT_B]           = init_q;
      end
      IDX_CTRL: begin
        host_rdata[EV_LSB +: NUM_EV] = en_q;
        host_rdata[CMD_W-1:0]        = cmd_q;
      end
      IDX_ALO: host_rdata = addr_q[HALF_W-1:0];
      IDX_AHI: host_rdata = addr_q[WORD_W-1:HALF_W];
      IDX_WLO: host_rdata = wdata_q[HALF_W-1:0];
      IDX_WHI: host_rdata = wdata_q[WORD_W-1:HALF_W];
      IDX_RLO: host_rdata = rdata_q[HALF_W-1:0];
      default: host_rdata = rdata_q[WORD_W-1:HALF_W];
    endcase
  end

  assign txn_addr  = addr_q;
  assign txn_wdata = wdata_q;
endmodule

// File: rtl/axbr_axil_engine.sv
module axbr_axil_engine
  import axbr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TIMEOUT_LIMIT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                start_wr,
  input  logic [WORD_W-1:0]   start_addr,
  input  logic [WORD_W-1:0]   start_wdata,
  output logic                busy,
  output logic                resp_fire,
  output logic                resp_err,
  output logic                to_fire,
  output logic [WORD_W-1:0]   m_awaddr,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [WORD_W-1:0]   m_wdata,
  output logic [WORD_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [WORD_W-1:0]   m_araddr,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_LIMIT - 1);

  logic              busy_q, wr_q, aw_pend, w_pend, ar_pend;
  logic [WORD_W-1:0] addr_q, wdata_q;
  logic [CNT_W-1:0]  cnt_q;

  assign busy      = busy_q;
  assign m_awaddr  = addr_q;
  assign m_araddr  = addr_q;
  assign m_wdata   = wdata_q;
  assign m_wstrb   = '1;
  assign m_awvalid = aw_pend;
  assign m_wvalid  = w_pend;
  assign m_arvalid = ar_pend;
  assign m_bready  = busy_q && wr_q;
  assign m_rready  = busy_q && !wr_q;

  always_comb begin
    resp_fire = (m_bvalid && m_bready) || (m_rvalid && m_rready);
    resp_err  = wr_q ? resp_bad(m_bresp) : resp_bad(m_rresp);
    to_fire   = busy_q && !resp_fire && (cnt_q == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      aw_pend <= 1'b0;
      w_pend  <= 1'b0;
      ar_pend <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        wr_q    <= start_wr;
        aw_pend <= start_wr;
        w_pend  <= start_wr;
        ar_pend <= !start_wr;
        addr_q  <= start_addr;
        wdata_q <= start_wdata;
        cnt_q   <= '0;
      end
    end else if (resp_fire || to_fire) begin
      busy_q  <= 1'b0;
      aw_pend <= 1'b0;
      w_pend  <= 1'b0;
      ar_pend <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (aw_pend && m_awready) aw_pend <= 1'b0;
      if (w_pend && m_wready)   w_pend  <= 1'b0;
      if (ar_pend && m_arready) ar_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/axbr_bridge.sv
module axbr_bridge
  import axbr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TIMEOUT_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic [2:0]  host_idx,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        ext_irq,
  output logic [31:0] m_awaddr,
  output logic        m_awvalid,
  input  logic        m_awready,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_wstrb,
  output logic        m_wvalid,
  input  logic        m_wready,
  input  logic [1:0]  m_bresp,
  input  logic        m_bvalid,
  output logic        m_bready,
  output logic [31:0] m_araddr,
  output logic        m_arvalid,
  input  logic        m_arready,
  input  logic [31:0] m_rdata,
  input  logic [1:0]  m_rresp,
  input  logic        m_rvalid,
  output logic        m_rready
);
  logic              eng_busy, resp_fire, resp_err, to_fire;
  logic              cmd_accept, cmd_is_wr;
  logic [WORD_W-1:0] txn_addr, txn_wdata;
  logic [NUM_EV-1:0] evt_q, en_q;

  axbr_regfile u_regs (
    .clk, .rst_n, .host_wr_en, .host_idx, .host_wdata, .host_rdata, .ext_irq,
    .eng_busy(eng_busy), .eng_resp_fire(resp_fire), .eng_resp_err(resp_err),
    .eng_to_fire(to_fire), .eng_rdata(m_rdata),
    .cmd_accept, .cmd_is_wr, .txn_addr, .txn_wdata, .evt_q, .en_q
  );

  axbr_axil_engine #(.CNT_W(CNT_W), .TIMEOUT_LIMIT(TIMEOUT_LIMIT)) u_eng (
    .clk, .rst_n,
    .start(cmd_accept), .start_wr(cmd_is_wr),
    .start_addr(txn_addr), .start_wdata(txn_wdata),
    .busy(eng_busy), .resp_fire, .resp_err, .to_fire,
    .m_awaddr, .m_awvalid, .m_awready, .m_wdata, .m_wstrb, .m_wvalid, .m_wready,
    .m_bresp, .m_bvalid, .m_bready, .m_araddr, .m_arvalid, .m_arready,
    .m_rresp, .m_rvalid, .m_rready
  );
endmodule

// File: rtl/axbr_bridge_chk.sv
module axbr_bridge_chk
  import axbr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [IDX_W-1:0]  host_idx,
  input logic [HALF_W-1:0] host_wdata,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [WORD_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [WORD_W-1:0] m_araddr,
  input logic              busy,
  input logic              resp_fire,
  input logic              to_fire,
  input logic [NUM_EV-1:0] evt_q,
  input logic [NUM_EV-1:0] en_q
);
  assert_one_channel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_arvalid && (m_awvalid || m_wvalid)));

  assert_aw_w_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_awvalid) |-> $rose(m_wvalid));

  assert_aw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready && !to_fire) |=> (m_awvalid && $stable(m_awaddr)));

  assert_ar_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready && !to_fire) |=> (m_arvalid && $stable(m_araddr)));

  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    to_fire |=> (!busy && !m_arvalid && !m_awvalid && !m_wvalid));

  assert_busy_locks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !resp_fire && !to_fire) |=>
      (busy && $stable(m_araddr) && $stable(m_awaddr)));

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    assert_event_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q[i]) |-> $past(en_q[i]));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[i] && !(host_wr_en && host_idx == IDX_STAT && host_wdata[EV_LSB+i]))
        |=> evt_q[i]);
  end
endmodule

bind axbr_bridge axbr_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_wr_en(host_wr_en), .host_idx(host_idx), .host_wdata(host_wdata),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
  .m_wvalid(m_wvalid), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_araddr(m_araddr), .busy(eng_busy), .resp_fire(resp_fire),
  .to_fire(to_fire), .evt_q(evt_q), .en_q(en_q)
);

// File: tb/axbr_bridge_tb_top.sv
`timescale 1ns/1ps
module axbr_bridge_tb_top;
  localparam int TO_LIM = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [2:0]  host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        ext_irq = 1'b0;
  logic [31:0] m_awaddr, m_wdata, m_araddr;
  logic [3:0]  m_wstrb;
  logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic        m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0, m_rvalid = 0;
  logic [1:0]  m_bresp = '0, m_rresp = '0;
  logic [31:0] m_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  axbr_bridge #(.TIMEOUT_LIMIT(TO_LIM)) dut_i (.*);

  // slave model state
  int          s_lat = 0;
  logic [1:0]  s_resp = '0;
  bit          s_silent = 1'b0;
  bit          ar_hs, aw_hs, w_hs, rsp_sent;
  int          ar_c, aw_c, w_c, r_c;
  logic [31:0] cap_araddr, cap_awaddr, cap_wdata;
  logic [3:0]  cap_wstrb;

  function automatic logic [31:0] slave_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [15:0] exp_status(input bit wr, input bit ok,
                                             input logic [4:0] en);
    logic [4:0] ev;
    ev = {!wr && ok, wr && ok, 1'b0, !ok, 1'b0} & en;
    return {ev, 3'b000, (!wr && ok), 1'b0, 1'b1, 5'b00000};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic slave_arm(input int lat, input logic [1:0] resp, input bit silent);
    s_lat = lat; s_resp = resp; s_silent = silent;
    ar_hs = 0; aw_hs = 0; w_hs = 0; rsp_sent = 0;
    ar_c = 0; aw_c = 0; w_c = 0; r_c = 0;
  endtask

  always @(negedge clk) begin
    m_arready = 0; m_awready = 0; m_wready = 0; m_rvalid = 0; m_bvalid = 0;
    if (!s_silent) begin
      if (ar_hs && !rsp_sent) begin
        if (r_c >= s_lat) begin
          m_rvalid = 1; m_rdata = slave_word(cap_araddr); m_rresp = s_resp; rsp_sent = 1;
        end else r_c++;
      end
      if (aw_hs && w_hs && !rsp_sent) begin
        if (r_c >= s_lat) begin
          m_bvalid = 1; m_bresp = s_resp; rsp_sent = 1;
        end else r_c++;
      end
      if (m_arvalid && !ar_hs) begin
        if (ar_c >= s_lat) begin m_arready = 1; ar_hs = 1; cap_araddr = m_araddr; end
        else ar_c++;
      end
      if (m_awvalid && !aw_hs) begin
        if (aw_c >= s_lat) begin m_awready = 1; aw_hs = 1; cap_awaddr = m_awaddr; end
        else aw_c++;
      end
      if (m_wvalid && !w_hs) begin
        if (w_c >= s_lat + 1) begin
          m_wready = 1; w_hs = 1; cap_wdata = m_wdata; cap_wstrb = m_wstrb;
        end else w_c++;
      end
    end
  end

  task automatic host_wr(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1; host_idx = idx; host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic host_rd(input logic [2:0] idx, output logic [15:0] d);
    host_idx = idx;
    #1;
    d = host_rdata;
  endtask

  task automatic run_txn(input bit wr, input bit inc, input logic [31:0] addr,
                         input logic [31:0] data, input int lat,
                         input logic [1:0] resp, input logic [4:0] en);
    logic [15:0] s, lo, hi;
    logic [3:0]  cmd;
    bit ok;
    ok = (resp == 2'b00);
    cmd = {2'b10, !wr, inc};
    slave_arm(lat, resp, 0);
    host_wr(3'd0, 16'hF800);
    host_wr(3'd2, addr[15:0]);
    host_wr(3'd3, addr[31:16]);
    if (wr) begin
      host_wr(3'd4, data[15:0]);
      host_wr(3'd5, data[31:16]);
    end
    host_wr(3'd1, {en, 7'd0, cmd});
    host_rd(3'd0, s);
    check(wr ? "R3 busy after accept" : "R4 busy after accept", 32'(s[6]), 32'd1);
    for (int k = 0; k < TO_LIM + 20; k++) begin
      @(negedge clk);
      host_rd(3'd0, s);
      if (!s[6]) break;
    end
    check(ok ? "R5 status after transfer" : "R8 status after error", 32'(s),
          32'(exp_status(wr, ok, en)));
    if (wr) begin
      check("R2 write address", cap_awaddr, addr);
      check("R2 write data", cap_wdata, data);
      check("R2 write strobe", 32'(cap_wstrb), 32'hF);
    end else begin
      check("R2 read address", cap_araddr, addr);
      if (ok) begin
        host_rd(3'd6, lo);
        host_rd(3'd7, hi);
        check("R4 read data", {hi, lo}, slave_word(addr));
      end
    end
    host_rd(3'd2, lo);
    host_rd(3'd3, hi);
    check(inc ? (ok ? "R7 address advanced" : "R8 no advance on error") : "R7 address kept",
          {hi, lo}, (inc && ok) ? addr + 32'd4 : addr);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s, d;
    void'($urandom(32'd20240611));
    slave_arm(0, 2'b00, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    host_rd(3'd0, s); check("R1 status after reset", 32'(s), 32'h0020);
    host_rd(3'd1, s); check("R1 control after reset", 32'(s), 32'h0);
    host_rd(3'd3, s); check("R1 address high after reset", 32'(s), 32'h0);
    host_rd(3'd7, s); check("R1 read data high after reset", 32'(s), 32'h0);

    // directed transfers
    run_txn(1, 0, 32'h1234_5678, 32'hDEAD_BEEF, 0, 2'b00, 5'b11110);
    run_txn(0, 0, 32'hCAFE_0010, 32'h0, 1, 2'b00, 5'b11110);
    run_txn(1, 1, 32'h0000_FFFC, 32'hA5A5_5A5A, 2, 2'b00, 5'b11110);
    run_txn(0, 1, 32'hFFFF_FFFC, 32'h0, 0, 2'b00, 5'b11110);
    run_txn(0, 1, 32'h4000_0100, 32'h0, 1, 2'b10, 5'b11110);
    run_txn(1, 1, 32'h4000_0200, 32'h1111_2222, 0, 2'b11, 5'b11110);
    run_txn(0, 0, 32'h0000_0040, 32'h0, 0, 2'b00, 5'b00000);
    run_txn(1, 0, 32'h0000_0080, 32'h7777_8888, 3, 2'b00, 5'b00000);

    // R6: sticky and write-one-to-clear
    run_txn(0, 0, 32'h0000_0100, 32'h0, 0, 2'b00, 5'b11110);
    repeat (5) @(negedge clk);
    host_wr(3'd0, 16'h0000);
    host_rd(3'd0, s); check("R6 event held after zero write", 32'(s[15]), 32'd1);
    host_wr(3'd0, 16'h4000);
    host_rd(3'd0, s); check("R6 other bit not cleared", 32'(s[15]), 32'd1);
    host_wr(3'd0, 16'h8000);
    host_rd(3'd0, s); check("R6 event cleared by one", 32'(s[15:11]), 32'd0);

    // R10: unknown codes when idle
    host_wr(3'd1, 16'hF805);
    host_rd(3'd0, s); check("R10 unknown code no busy", 32'(s[6]), 32'd0);
    check("R10 unknown code no valid", 32'({m_arvalid, m_awvalid, m_wvalid}), 32'd0);
    host_wr(3'd1, 16'hF800);
    host_rd(3'd0, s); check("R10 nop no busy", 32'(s[6]), 32'd0);

    // R9 and R10: silent slave
    slave_arm(0, 2'b00, 1);
    host_wr(3'd0, 16'hF800);
    host_wr(3'd2, 16'h0500);
    host_wr(3'd3, 16'h0000);
    host_wr(3'd1, 16'hF808);
    host_wr(3'd1, 16'hF80A);
    host_rd(3'd0, s);
    check("R10 command ignored while busy", 32'({m_arvalid, m_awvalid}), 32'b01);
    check("R10 address unchanged while busy", m_awaddr, 32'h0000_0500);
    repeat (TO_LIM - 3) @(negedge clk);
    host_rd(3'd0, s);
    check("R9 busy held until limit", 32'({s[6], s[13], m_awvalid}), 32'b101);
    @(negedge clk);
    host_rd(3'd0, s);
    check("R9 timeout status", 32'(s), 32'h2020);
    check("R9 valids dropped", 32'({m_awvalid, m_wvalid, m_arvalid}), 32'd0);
    slave_arm(0, 2'b00, 0);
    host_wr(3'd0, 16'hF800);

    // R11: external interrupt gated by enable
    host_wr(3'd1, 16'h0800);
    @(negedge clk); ext_irq = 1;
    @(negedge clk); ext_irq = 0;
    host_rd(3'd0, s); check("R11 irq event set", 32'(s[11]), 32'd1);
    host_wr(3'd0, 16'h0800);
    host_wr(3'd1, 16'h0000);
    @(negedge clk); ext_irq = 1;
    @(negedge clk); ext_irq = 0;
    host_rd(3'd0, s); check("R5 irq masked", 32'(s[11]), 32'd0);

    // constrained random transfers
    for (int i = 0; i < 40; i++) begin
      logic [1:0] rsp;
      rsp = ($urandom % 5 == 0) ? 2'(2 + ($urandom % 2)) : 2'b00;
      run_txn(1'($urandom), 1'($urandom), $urandom, $urandom, int'($urandom % 4),
              rsp, 5'($urandom) & 5'b11110);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule